// File: doc/BRIEF.md
# Two-Polarity Byte Memory Self-Test Engine

This engine drives a byte-wide synchronous RAM through a test of a programmable address range, by default from 0x2000 up to 0xFEFF. A pulse on `start` latches the first and last address. The engine then visits each address in ascending order. At each one it writes a byte from a rolling pattern counter, reads the byte back and compares it. It then writes the bitwise inverse of the pattern, reads that back, and inverts the read value before comparing it with the pattern again. Testing every bit in both polarities exposes bits that are stuck at 0 and bits that are stuck at 1.

The pattern is 0 at the first address and rises by one for each following address, wrapping from 255 to 0. The first miscompare ends the run. The engine then holds the failing address, the pattern byte it expected and the byte it got until the next start. A clean run ends with `done` high and `fail` low. The RAM is expected to return read data on the clock edge after the one that samples `mem_re`.

Top module: `mem_selftest`

## Requirements
- R1: While reset is high and in the cycle after it is released, busy, done, fail, mem_we and mem_re are all 0.
- R2: A start pulse seen while busy is low begins a run from the next cycle: busy is 1, and done and fail are 0. A start pulse seen while busy is high has no effect on the addresses, timing or result of the run in progress.
- R3: Addresses are visited from start_addr up to end_addr inclusive, one after the other. The pattern byte at address A is (A - start_addr) mod 256, so it wraps from 255 to 0.
- R4: Each address takes exactly six cycles, in this order: write the pattern, read, check, write the inverted pattern, read, check. Every write is followed in the very next cycle by a read of the same address, and mem_we and mem_re are never high together.
- R5: The second check passes only when the bitwise inverse of the byte read back equals the pattern.
- R6: A clean run over N addresses sets done, clears busy and leaves fail at 0, all at the clock edge that comes 6·N edges after the edge that accepted start.
- R7: On the first miscompare at the k-th address of the range (k from 0), the engine sets fail and done and clears busy. This happens 6k+3 edges after the start edge for a plain-pass miscompare and 6k+6 edges after it for an inverted-pass miscompare. fail_addr holds that address and fail_exp holds the pattern byte. fail_got holds the byte read in the plain pass, or its bitwise inverse in the inverted pass.
- R8: A single bit stuck at 0 or at 1 at any address in the range is reported at that address. It is caught by the plain pass when the pattern bit differs from the stuck value, and by the inverted pass otherwise.
- R9: done, fail, fail_addr, fail_exp and fail_got hold their values after a run until the next accepted start.
- R10: While busy, mem_addr stays between the latched start and end addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when the engine is idle |
| start_addr | input | AW | First address to test |
| end_addr | input | AW | Last address to test |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | DW | RAM read data, valid one cycle after mem_re |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (pass or fail) |
| fail | output | 1 | Run stopped on a miscompare |
| fail_addr | output | AW | Address of the first miscompare |
| fail_exp | output | DW | Pattern byte expected there |
| fail_got | output | DW | Byte obtained (inverted for the second pass) |

## Verification
A wrong sequencer state shows up on the RAM pins within one cycle. The engine might write a byte that is not the inverse at the point where it should be, skip the read that must follow a write, or assert the two enables together. A bench-side monitor compares each of these against the address and pattern predicted for that point in the run. A wrong pattern or address counter shows as a wrong write byte at the next address. A faulty comparator or fail latch shows at done: the run ends at the wrong edge count, or the reported address, expected byte or obtained byte disagrees with a fault that the bench places at a known bit, address and polarity.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_CHK,
    ST_WRC,
    ST_RDC,
    ST_CHKC
  } mst_state_e;
endpackage

// File: rtl/mst_pattern.sv
module mst_pattern #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  output logic [DW-1:0] pat
);
  always_ff @(posedge clk) begin
    if (rst || load) pat <= '0;
    else if (step)   pat <= pat + DW'(1);
  end

  // R3
  pat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> pat == DW'($past(pat) + DW'(1)));
endmodule

// File: rtl/mst_addr_seq.sv
module mst_addr_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          busy,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic [AW-1:0] cur_addr,
  output logic          last
);
  logic [AW-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else if (load) begin
      cur_addr <= start_addr;
      lo_q     <= start_addr;
      hi_q     <= end_addr;
    end else if (step) begin
      cur_addr <= cur_addr + AW'(1);
    end
  end

  assign last = (cur_addr == hi_q);

  // R10
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cur_addr >= lo_q && cur_addr <= hi_q));
endmodule

// File: rtl/mst_compare.sv
module mst_compare #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          chk_en,
  input  logic          inv,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] pat,
  input  logic [DW-1:0] rdata,
  output logic          mismatch,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_got
);
  logic [DW-1:0] got;

  assign got      = inv ? ~rdata : rdata;
  assign mismatch = chk_en && (got != pat);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_got  <= '0;
    end else if (mismatch) begin
      fail      <= 1'b1;
      fail_addr <= addr;
      fail_exp  <= pat;
      fail_got  <= got;
    end
  end

  // R9
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !clear) |=> (fail && $stable(fail_addr) && $stable(fail_got)));
endmodule

// File: rtl/mst_ctrl.sv
module mst_ctrl
  import mst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       mismatch,
  input  logic       last,
  output mst_state_e state,
  output logic       load,
  output logic       step,
  output logic       busy,
  output logic       done
);
  mst_state_e nxt;
  logic       finish;

  assign load = (state == ST_IDLE) && start;

  always_comb begin
    nxt    = state;
    step   = 1'b0;
    finish = 1'b0;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_WR;
      ST_WR:   nxt = ST_RD;
      ST_RD:   nxt = ST_CHK;
      ST_CHK: begin
        if (mismatch) begin
          nxt = ST_IDLE;
          finish = 1'b1;
        end else nxt = ST_WRC;
      end
      ST_WRC:  nxt = ST_RDC;
      ST_RDC:  nxt = ST_CHKC;
      ST_CHKC: begin
        if (mismatch || last) begin
          nxt = ST_IDLE;
          finish = 1'b1;
        end else begin
          nxt  = ST_WR;
          step = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      if (load) begin
        busy <= 1'b1;
        done <= 1'b0;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && !done));
endmodule

// File: rtl/mem_selftest.sv
module mem_selftest
  import mst_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_got
);
  mst_state_e    state;
  logic          load, step, last, mismatch;
  logic [DW-1:0] pat;
  logic [AW-1:0] cur_addr;

  mst_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mismatch(mismatch), .last(last),
    .state(state), .load(load), .step(step), .busy(busy), .done(done)
  );

  mst_pattern #(.DW(DW)) u_pat (
    .clk(clk), .rst(rst), .load(load), .step(step), .pat(pat)
  );

  mst_addr_seq #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .load(load), .step(step), .busy(busy),
    .start_addr(start_addr), .end_addr(end_addr),
    .cur_addr(cur_addr), .last(last)
  );

  mst_compare #(.AW(AW), .DW(DW)) u_cmp (
    .clk(clk), .rst(rst), .clear(load),
    .chk_en(state == ST_CHK || state == ST_CHKC),
    .inv(state == ST_CHKC), .addr(cur_addr), .pat(pat), .rdata(mem_rdata),
    .mismatch(mismatch), .fail(fail), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_got(fail_got)
  );

  assign mem_addr  = cur_addr;
  assign mem_we    = (state == ST_WR) || (state == ST_WRC);
  assign mem_re    = (state == ST_RD) || (state == ST_RDC);
  assign mem_wdata = (state == ST_WRC) ? ~pat : pat;

  // R4
  we_re_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
  // R4
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (mem_re && mem_addr == $past(mem_addr)));
  // R7
  fail_done_chk: assert property (@(posedge clk) disable iff (rst)
    fail |-> (done && !busy));
endmodule

// File: tb/sim_mem_selftest.sv
module sim_mem_selftest;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_we, mem_re, busy, done, fail;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_exp, fail_got;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  mem_selftest #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .end_addr(end_addr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_got(fail_got)
  );

  // RAM model with one injectable stuck bit
  logic [DW-1:0] ram [0:1023];
  logic          flt_en = 1'b0, flt_one = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic [DW-1:0] flt_mask = '0;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
    if (mem_re) begin
      if (flt_en && mem_addr == flt_addr)
        mem_rdata <= flt_one ? (ram[mem_addr[9:0]] | flt_mask)
                             : (ram[mem_addr[9:0]] & ~flt_mask);
      else
        mem_rdata <= ram[mem_addr[9:0]];
    end
  end

  // Port protocol monitor (R3, R4)
  int            mon_err = 0;
  int            widx = 0;
  logic [AW-1:0] mon_start = '0;
  logic          prev_we = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  always @(posedge clk) begin
    if (!rst) begin
      if (prev_we && !(mem_re && mem_addr == prev_addr)) mon_err++;
      if (mem_we && mem_re) mon_err++;
      if (start && !busy) widx = 0;
      else if (mem_we) begin
        if (mem_addr != AW'(mon_start + AW'(widx / 2))) mon_err++;
        if (mem_wdata != ((widx % 2 == 0) ? DW'(widx / 2) : ~DW'(widx / 2)))
          mon_err++;
        widx++;
      end
    end
    prev_we   <= mem_we;
    prev_addr <= mem_addr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one test and compares against a prediction made from the requirements
  task automatic run(input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                     input bit fe, input logic [AW-1:0] fa, input int fb,
                     input bit f1, input bit poke);
    int            cyc, exp_cyc, k;
    bit            exp_fail;
    logic [DW-1:0] p, r, exp_got;
    flt_en = fe; flt_addr = fa; flt_mask = DW'(1) << fb; flt_one = f1;
    mon_start = lo;
    mon_err = 0;
    @(negedge clk);
    start_addr = lo; end_addr = hi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    start_addr = '0; end_addr = '0;
    chk(busy && !done && !fail, "R2 run begins", {busy, done, fail}, 3'b100);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 10) start = 1'b1;
      if (poke && cyc == 11) start = 1'b0;
    end
    start = 1'b0;
    exp_fail = 1'b0; exp_got = '0;
    exp_cyc = 6 * (int'(hi) - int'(lo) + 1);
    if (fe && fa >= lo && fa <= hi) begin
      k = int'(fa) - int'(lo);
      p = DW'(k);
      r = f1 ? (p | flt_mask) : (p & ~flt_mask);
      exp_fail = 1'b1;
      if (r != p) begin
        exp_got = r; exp_cyc = 6 * k + 3;
      end else begin
        r = f1 ? (~p | flt_mask) : (~p & ~flt_mask);
        exp_got = ~r; exp_cyc = 6 * k + 6;
      end
      chk(fail_addr == fa, "R7 fail_addr", fail_addr, fa);
      chk(fail_exp == p, "R7 fail_exp", fail_exp, p);
      chk(fail_got == exp_got, "R8 fail_got", fail_got, exp_got);
    end
    chk(cyc == exp_cyc, exp_fail ? "R7 stop edge" : "R6 done edge", cyc, exp_cyc);
    chk(done && !busy && fail == exp_fail, "R6 end flags", {done, busy, fail},
        {1'b1, 1'b0, exp_fail});
    chk(mon_err == 0, "R4 R3 R5 write/read sequence", mon_err, 0);
    repeat (5) @(negedge clk);
    chk(done && fail == exp_fail && (!exp_fail || fail_got == exp_got),
        "R9 hold", {done, fail}, {1'b1, exp_fail});
    flt_en = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !mem_we && !mem_re, "R1 in reset",
        {busy, done, fail, mem_we, mem_re}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fail && !mem_we && !mem_re, "R1 after reset",
        {busy, done, fail, mem_we, mem_re}, 0);
  endtask

  task automatic t_clean;     run(16'h2000, 16'h2003, 0, 0, 0, 0, 0); endtask
  task automatic t_single;    run(16'h2100, 16'h2100, 0, 0, 0, 0, 0); endtask
  task automatic t_wrap;      run(16'h2000, 16'h212B, 0, 0, 0, 0, 0); endtask  // R3 wrap
  task automatic t_stuck0_pl; run(16'h2000, 16'h2010, 1, 16'h2005, 0, 0, 0); endtask // R8 plain
  task automatic t_stuck0_iv; run(16'h2000, 16'h2010, 1, 16'h2006, 0, 0, 0); endtask // R8/R5 inverted
  task automatic t_stuck1_iv; run(16'h2000, 16'h2010, 1, 16'h2005, 0, 1, 0); endtask // R5 inverted
  task automatic t_stuck1_pl; run(16'h2000, 16'h2010, 1, 16'h2000, 7, 1, 0); endtask // R8 first addr
  task automatic t_wrap_flt;  run(16'h2000, 16'h212B, 1, 16'h210E, 3, 1, 0); endtask // R3 R8
  task automatic t_last_flt;  run(16'h3000, 16'h3007, 1, 16'h3007, 5, 0, 0); endtask // R8 end addr
  task automatic t_restart;   run(16'h2000, 16'h2008, 1, 16'h2004, 2, 0, 1); endtask // R2 ignored
  task automatic t_outside;   run(16'h2000, 16'h2005, 1, 16'h2009, 1, 1, 0); endtask // R10

  initial begin
    fork
      begin
        t_reset();
        t_clean();
        t_single();
        t_wrap();
        t_stuck0_pl();
        t_stuck0_iv();
        t_stuck1_iv();
        t_stuck1_pl();
        t_wrap_flt();
        t_last_flt();
        t_restart();
        t_outside();
        t_clean();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule